// File: doc/BRIEF.md
# Dual-Compare PWM Timer Channel

A single timer channel built around a 16-bit up-counter. The counter advances on a clock tick chosen from three source-tick inputs and slowed by a programmable power-of-four prescaler. Two compare registers shape its cycle. The "full" value sets the period: on reaching it the counter wraps to zero. The "half" value sets the duty: on reaching it the PWM level flips away from its programmed idle level. Each match gives a one-cycle event pulse that a shared interrupt block can gather.

Software reaches the channel through a word-addressed 32-bit register port. The channel occupies a 16-byte window at 0x40 + 0x10 × CHAN and holds full data, half data, counter and control registers. Two run-control inputs come from a shared bank: enable and stop. A control word selects the idle level, output enable, shutdown, counter clear, clock bypass and an input-enable flag. The parameter MODE (1 or 2) decides whether the shutdown bit or the clear bit is honoured.

Top module: `pwm_timer_chan`

## Requirements
- R1: Registers sit at byte offsets from the channel base 0x40+0x10·CHAN: full compare +0x0, half compare +0x4, counter +0x8, control +0xC. Full and half hold 16 bits and control holds 12 bits. Unstored upper bits read 0, and a read of any other or unaligned address returns 0.
- R2: A write to the counter register loads bits 15:0 into the count immediately, and a read returns the current count.
- R3: The counter and prescaler advance only while chan_en is 1 and chan_stop is 0. Otherwise the count holds its value.
- R4: Control bits 2:0 gate the three source inputs: bit i admits src_tick[i]. With no bit set, the counter does not advance.
- R5: Control bits 5:3 hold a prescale code k. One count tick occurs per 4^k admitted source ticks. Codes 6 and 7 act as code 5, which divides by 1024.
- R6: On a count tick while the count equals the half value, half_evt pulses for one cycle and the PWM level switches to the inverse of the idle level.
- R7: On a count tick while the count equals the full value, full_evt pulses for one cycle, the count becomes 0 and the level returns to idle. The period is therefore (full+1)·4^k ticks.
- R8: Control bit 8 is the idle level and bit 7 enables the output. While bit 7 is 0, pwm_out equals the idle level.
- R9: With MODE=1, control bit 9 holds pwm_out at the idle level. With MODE=2, bit 9 has no effect on the pin.
- R10: With MODE=2, control bit 10 holds the count at 0 while it is set. With MODE=1, it has no effect on counting.
- R11: Control bit 11, with the output enabled, drives pwm_out from the admitted source tick directly instead of the compare level.
- R12: Control bit 6 (input enable) is stored and read back, and it changes neither the period nor the duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| chan_en | input | 1 | Run enable from the shared control bank |
| chan_stop | input | 1 | Stop request from the shared control bank |
| src_tick | input | 3 | Clock-enable pulses from three candidate sources |
| pwm_out | output | 1 | PWM pin level |
| full_evt | output | 1 | One-cycle pulse on period match |
| half_evt | output | 1 | One-cycle pulse on duty match |

## Verification
The hardest state to reach from the ports is the top prescale code. At that code a full period lasts thousands of cycles, and an off-by-one in the divider width only shows as a wrong period there. The bench programs codes 6 and 7 with a full value of 1 and times whole periods between full-match pulses, expecting 2048 cycles. The mode-dependent bits need two channels side by side. A MODE=1 and a MODE=2 instance share the same bus so that one write shows the honoured and the ignored behaviour at the same time.

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan #(
  parameter int CHAN    = 0,
  parameter int MODE    = 2,
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 16,
  parameter int PRE_MAX = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              chan_en,
  input  logic              chan_stop,
  input  logic [2:0]        src_tick,
  output logic              pwm_out,
  output logic              full_evt,
  output logic              half_evt
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(32'h40 + 32'h10 * CHAN);
  localparam int PW = 2 * PRE_MAX;
  localparam int CTL_W = 12;
  localparam int B_IN = 6, B_OE = 7, B_INIT = 8, B_SD = 9, B_CLR = 10, B_BYP = 11;

  logic [CNT_W-1:0] full_q, half_q, cnt_q;
  logic [CTL_W-1:0] ctrl_q;
  logic [PW-1:0]    pcnt_q, pre_lim;
  logic             phase_q;
  logic [2:0]       pre_k;
  logic             sel, run, src_on, tick, clr_hold, sd_act, drive;
  logic             wr_full, wr_half, wr_cnt, wr_ctrl;
  logic             unused_bits;

  assign unused_bits = ^reg_wdata[31:16];

  assign sel     = (reg_addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]) && (reg_addr[1:0] == 2'b00);
  assign wr_full = reg_wr && sel && reg_addr[3:2] == 2'd0;
  assign wr_half = reg_wr && sel && reg_addr[3:2] == 2'd1;
  assign wr_cnt  = reg_wr && sel && reg_addr[3:2] == 2'd2;
  assign wr_ctrl = reg_wr && sel && reg_addr[3:2] == 2'd3;

  always_comb begin
    reg_rdata = '0;
    if (sel) begin
      case (reg_addr[3:2])
        2'd0:    reg_rdata = 32'(full_q);
        2'd1:    reg_rdata = 32'(half_q);
        2'd2:    reg_rdata = 32'(cnt_q);
        default: reg_rdata = 32'(ctrl_q);
      endcase
    end
  end

  assign run      = chan_en && !chan_stop;
  assign src_on   = |(ctrl_q[2:0] & src_tick);
  assign pre_k    = (ctrl_q[5:3] > 3'(PRE_MAX)) ? 3'(PRE_MAX) : ctrl_q[5:3];
  assign pre_lim  = (PW'(1) << (2 * pre_k)) - PW'(1);
  assign tick     = run && src_on && (pcnt_q >= pre_lim);
  assign clr_hold = (MODE == 2) && ctrl_q[B_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      half_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_full) full_q <= reg_wdata[CNT_W-1:0];
      if (wr_half) half_q <= reg_wdata[CNT_W-1:0];
      if (wr_ctrl) ctrl_q <= reg_wdata[CTL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pcnt_q <= '0;
    else if (run && src_on)
      pcnt_q <= (pcnt_q >= pre_lim) ? '0 : pcnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      phase_q  <= 1'b0;
      full_evt <= 1'b0;
      half_evt <= 1'b0;
    end else begin
      full_evt <= 1'b0;
      half_evt <= 1'b0;
      if (clr_hold) begin
        cnt_q   <= '0;
        phase_q <= 1'b0;
      end else if (wr_cnt) begin
        cnt_q   <= reg_wdata[CNT_W-1:0];
        phase_q <= 1'b0;
      end else if (tick) begin
        if (cnt_q == half_q) begin
          half_evt <= 1'b1;
          phase_q  <= 1'b1;
        end
        if (cnt_q == full_q) begin
          full_evt <= 1'b1;
          phase_q  <= 1'b0;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign sd_act  = (MODE == 1) && ctrl_q[B_SD];
  assign drive   = ctrl_q[B_OE] && !sd_act;
  assign pwm_out = drive ? (ctrl_q[B_BYP] ? src_on : (ctrl_q[B_INIT] ^ phase_q))
                         : ctrl_q[B_INIT];

  // R7
  full_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_evt |-> cnt_q == '0);

  // R6
  half_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_evt && !full_evt) |-> phase_q);

  // R3
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt && !clr_hold) |=> $stable(cnt_q));

  generate
    if (MODE == 2) begin : g_clr_chk
      // R10
      clear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[B_CLR] |=> cnt_q == '0);
    end
  endgenerate

  // R1
  read_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && reg_addr[3:2] != 2'd3) |-> reg_rdata[31:CNT_W] == '0);

  logic unused_in;
  assign unused_in = ctrl_q[B_IN];
endmodule

// File: tb/pwm_timer_chan_test.sv
module pwm_timer_chan_test;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  reg_addr = 0;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic        chan_en = 0, chan_stop = 0;
  logic [1:0]  div3 = 0;
  logic [2:0]  src_tick;
  logic [31:0] rdata, rdata1;
  logic        pwm, fe, he, pwm1, fe1, he1;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [7:0] A_FULL = 8'h40, A_HALF = 8'h44, A_CNT = 8'h48, A_CTRL = 8'h4C;
  localparam logic [31:0] SRC0 = 32'h1, SRC1 = 32'h2, PIN_IN = 32'h40, OE = 32'h80,
                          INIT = 32'h100, SD = 32'h200, CLR = 32'h400, BYP = 32'h800;

  always #5 clk = ~clk;

  always @(negedge clk) div3 <= (div3 == 2'd2) ? 2'd0 : div3 + 2'd1;
  assign src_tick = {1'b0, div3 == 2'd0, 1'b1};

  pwm_timer_chan #(.MODE(2)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata), .chan_en(chan_en), .chan_stop(chan_stop), .src_tick(src_tick),
    .pwm_out(pwm), .full_evt(fe), .half_evt(he));

  pwm_timer_chan #(.MODE(1)) uut_m1 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata1), .chan_en(chan_en), .chan_stop(chan_stop), .src_tick(src_tick),
    .pwm_out(pwm1), .full_evt(fe1), .half_evt(he1));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #2;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0; #2;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d, output logic [31:0] d1);
    reg_addr = a; #1;
    d = rdata; d1 = rdata1;
  endtask

  task automatic setup(logic [31:0] ctrl, logic [15:0] full, logic [15:0] half);
    chan_en = 0;
    wr(A_CTRL, ctrl); wr(A_FULL, 32'(full)); wr(A_HALF, 32'(half)); wr(A_CNT, 0);
    chan_en = 1;
  endtask

  task automatic wait_full(output int cyc);
    cyc = 0;
    do begin step(); cyc++; end while (!fe && cyc < 5000);
  endtask

  task automatic period(output int p);
    int c;
    wait_full(c);
    wait_full(p);
  endtask

  task automatic count_hi(int n, output int hi, output int hi1, output int hev);
    hi = 0; hi1 = 0; hev = 0;
    for (int i = 0; i < n; i++) begin
      step();
      hi += pwm; hi1 += pwm1; hev += he;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d, d1;
    rd(A_FULL, d, d1); chk("R1 reset full", d, 0);
    rd(A_CNT, d, d1);  chk("R1 reset cnt", d, 0);
    rd(A_CTRL, d, d1); chk("R1 reset ctrl", d, 0);
    chk("R8 reset pin", 32'(pwm), 0);
    chk("R7 reset full_evt", 32'(fe), 0);
  endtask

  task automatic t_regs();
    logic [31:0] d, d1;
    wr(A_FULL, 32'hABCD1234); rd(A_FULL, d, d1); chk("R1 full width", d, 32'h1234);
    wr(A_HALF, 32'h5555BEEF); rd(A_HALF, d, d1); chk("R1 half width", d, 32'hBEEF);
    wr(A_CTRL, 32'hFFFF_F1FF); rd(A_CTRL, d, d1); chk("R1 ctrl width", d, 32'h1FF);
    wr(A_CTRL, 0);
    rd(8'h50, d, d1); chk("R1 other channel", d, 0);
    rd(8'h42, d, d1); chk("R1 unaligned", d, 0);
  endtask

  task automatic t_load();
    logic [31:0] d, d1;
    chan_en = 0;
    wr(A_CNT, 32'hFFFF00AB); rd(A_CNT, d, d1); chk("R2 counter load", d, 32'hAB);
  endtask

  task automatic t_duty();
    int p, hi, hi1, hev;
    logic [31:0] d, d1;
    setup(SRC0 | OE | PIN_IN, 5, 2);
    rd(A_CTRL, d, d1); chk("R12 input flag readback", d, SRC0 | OE | PIN_IN);
    period(p); chk("R7 period full=5", p, 6);
    chk("R7 level idle after full match", 32'(pwm), 0);
    count_hi(6, hi, hi1, hev);
    chk("R6 high share of period", hi, 3);
    chk("R6 one half pulse per period", hev, 1);
    chk("R12 input flag leaves duty", hi1, 3);
    do step(); while (!he);
    chk("R6 level inverted after half match", 32'(pwm), 1);
  endtask

  task automatic t_presc();
    int p;
    setup(SRC0 | (32'd1 << 3), 3, 0); period(p); chk("R5 code 1 period", p, 16);
    setup(SRC0 | (32'd2 << 3), 3, 0); period(p); chk("R5 code 2 period", p, 64);
    setup(SRC0 | (32'd6 << 3), 1, 0); period(p); chk("R5 code 6 as 5", p, 2048);
    setup(SRC0 | (32'd7 << 3), 1, 0); period(p); chk("R5 code 7 as 5", p, 2048);
  endtask

  task automatic t_gate();
    logic [31:0] a, b, a1, b1;
    setup(SRC0, 16'hFFFF, 16'hFFFF);
    repeat (3) step();
    chan_stop = 1; step();
    rd(A_CNT, a, a1); repeat (5) step(); rd(A_CNT, b, b1);
    chk("R3 stop freezes", b, a);
    chk("R3 stop freezes mode1", b1, a1);
    chan_stop = 0; repeat (4) step(); rd(A_CNT, b, b1);
    chk("R3 runs again", b, a + 4);
    chan_en = 0; step(); rd(A_CNT, a, a1); repeat (5) step(); rd(A_CNT, b, b1);
    chk("R3 enable low freezes", b, a);
  endtask

  task automatic t_src();
    logic [31:0] a, b, a1;
    int p;
    setup(0, 16'hFFFF, 16'hFFFF);
    repeat (5) step(); rd(A_CNT, a, a1);
    chk("R4 no source no count", a, 0);
    setup(SRC1, 2, 0); period(p); chk("R4 slow source period", p, 9);
    setup(SRC0, 16'hFFFF, 16'hFFFF);
    step(); rd(A_CNT, a, a1); repeat (6) step(); rd(A_CNT, b, a1);
    chk("R4 fast source", b, a + 6);
  endtask

  task automatic t_idle();
    int p, hi, hi1, hev;
    setup(SRC0 | INIT, 5, 2);
    count_hi(12, hi, hi1, hev); chk("R8 disabled pin holds idle", hi, 12);
    setup(SRC0 | INIT | OE, 5, 2);
    wait_full(p);
    chk("R8 idle high after full match", 32'(pwm), 1);
    count_hi(6, hi, hi1, hev); chk("R8 inverted duty", hi, 3);
  endtask

  task automatic t_sd();
    int hi, hi1, hev;
    setup(SRC0 | OE | SD, 5, 2);
    count_hi(12, hi, hi1, hev);
    chk("R9 shutdown holds idle in mode 1", hi1, 0);
    chk("R9 shutdown ignored in mode 2", hi, 6);
  endtask

  task automatic t_clr();
    logic [31:0] a, a1;
    setup(SRC0 | CLR, 16'hFFFF, 16'hFFFF);
    repeat (5) step(); rd(A_CNT, a, a1);
    chk("R10 clear holds zero in mode 2", a, 0);
    chk("R10 clear ignored in mode 1", a1 != 0, 1);
    wr(A_CTRL, SRC0); repeat (3) step(); rd(A_CNT, a, a1);
    chk("R10 counting after clear release", a != 0, 1);
  endtask

  task automatic t_byp();
    int mism = 0, hi = 0;
    setup(SRC1 | OE | BYP, 5, 2);
    for (int i = 0; i < 9; i++) begin
      step();
      if (pwm !== src_tick[1]) mism++;
      hi += pwm;
    end
    chk("R11 bypass follows source", mism, 0);
    chk("R11 bypass high count", hi, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    t_reset();
    t_regs();
    t_load();
    t_duty();
    t_presc();
    t_gate();
    t_src();
    t_idle();
    t_sd();
    t_clr();
    t_byp();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule